// File: doc/BRIEF.md
# Ping-Pong Frame Result Queue Controller

This block keeps per-row results for a frame-based readout loop in two equal memory banks that take turns. While the arithmetic stage writes the current frame's results into one bank at the present row address, the other bank holds the full previous frame. Two read paths use that older bank. A control path hands one word per row to a downstream correction stage with a fixed latency after the row strobe. A bus path lets software fetch any previous-frame word at any time. Because readers and the writer never share a bank, no arbitration is needed.

Frame timing comes from three strobes. A row strobe advances the row address. A frame-restart strobe swaps the bank roles and returns the row address to zero. A late frame strobe, issued one row after the restart, marks the previous bank as holding a complete frame. During the initialize window both read paths return the fixed preset value zero. The word is stored only when the write strobe comes with a non-zero servo mode. The reset input is asynchronous and active low, and it must be released in step with the clock.

Top module: `frame_queue_ctrl`

## Requirements
- R1: There are two banks of 2**ADDR_W words of DATA_W bits (defaults 64 x 40). Writes go to the current bank. Both read paths read only the other bank, which holds the previous frame.
- R2: A word is written at the current row address only when wr_en_i is high and mode_i is not 2'b00. With mode_i = 2'b00 the bank keeps its old content, which can then be seen one frame later.
- R3: On the clock edge that samples frame_restart_i high, the current/previous roles of the banks swap and the row address becomes 0. This holds even if row_switch_i is high on the same edge.
- R4: On each edge that samples row_switch_i high without frame_restart_i, the row address goes up by one. It stops at 2**ADDR_W-1.
- R5: ctrl_rdy_o is a one-cycle pulse CTRL_LAT cycles (default 4) after the cycle in which row_switch_i is high. With it, ctrl_dat_o carries the previous-frame word at the row address set by that strobe. ctrl_dat_o changes only on the cycle ctrl_rdy_o rises.
- R6: bus_dat_o gives the previous-frame word at bus_addr_i one cycle after the address is presented, at any point in the frame.
- R7: While init_win_i is high, both read paths return zero. An edge with init_win_i high also clears the primed state.
- R8: After reset or an initialize window, both read paths return zero until frame_restart_late_i has been sampled high.
- R9: After reset, ctrl_rdy_o is low and ctrl_dat_o and bus_dat_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_switch_i | input | 1 | One-cycle pulse: a new row starts |
| frame_restart_i | input | 1 | One-cycle pulse: a new frame starts |
| frame_restart_late_i | input | 1 | One-cycle pulse one row after the frame start |
| init_win_i | input | 1 | Initialize window: reads return zero |
| wr_en_i | input | 1 | Result update strobe from the arithmetic stage |
| mode_i | input | 2 | Servo mode (00 off, 01 constant, 10 ramp, 11 lock) |
| wr_data_i | input | DATA_W | Result word to store |
| bus_addr_i | input | ADDR_W | Bus read address into the previous frame |
| ctrl_dat_o | output | DATA_W | Previous-frame word for the current row |
| ctrl_rdy_o | output | 1 | One-cycle qualifier for ctrl_dat_o |
| bus_dat_o | output | DATA_W | Bus read data |

## Verification
The hardest state to reach from the ports is a bank whose content is older than one frame. This happens after a frame in which every update came with mode 2'b00, and after a frame long enough to pin the row address at its top value. The stimulus uses directed frames for both: a frame of only suppressed writes, and a frame of 70 rows. Random frames fill in around them. The bench then reads the stale words in the following frame through both read paths. It also runs a full initialize window followed by the first rows of the next frame, where the zero gating must stay in force until the late frame strobe arrives.

// File: rtl/frame_queue_pkg.sv
package frame_queue_pkg;

  typedef enum logic [1:0] {
    SERVO_OFF   = 2'b00,
    SERVO_CONST = 2'b01,
    SERVO_RAMP  = 2'b10,
    SERVO_LOCK  = 2'b11
  } servo_mode_e;

  // Only a selected servo mode produces a queue update.
  function automatic logic mode_updates(servo_mode_e m);
    return m != SERVO_OFF;
  endfunction

endpackage

// File: rtl/fq_bank_ram.sv
// One result bank: a write port and two registered read ports.
module fq_bank_ram #(
  parameter int DATA_W = 40,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

endmodule

// File: rtl/fq_row_tracker.sv
// Bank role, row address and primed state driven by the frame strobes.
module fq_row_tracker #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_switch_i,
  input  logic              restart_i,
  input  logic              restart_late_i,
  input  logic              init_i,
  output logic              cur_bank_o,
  output logic [ADDR_W-1:0] row_o,
  output logic              primed_o
);
  localparam logic [ADDR_W-1:0] ROW_MAX = {ADDR_W{1'b1}};

  logic              bank_d, primed_d;
  logic [ADDR_W-1:0] row_d;

  always_comb begin
    bank_d = cur_bank_o ^ restart_i;
    row_d  = row_o;
    if (restart_i)                            row_d = '0;
    else if (row_switch_i && row_o != ROW_MAX) row_d = row_o + 1'b1;
    primed_d = primed_o;
    if (init_i)              primed_d = 1'b0;
    else if (restart_late_i) primed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_bank_o <= 1'b0;
      row_o      <= '0;
      primed_o   <= 1'b0;
    end else begin
      cur_bank_o <= bank_d;
      row_o      <= row_d;
      primed_o   <= primed_d;
    end
  end

  a_r3_bank_swap: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> cur_bank_o != $past(cur_bank_o));
  a_r3_row_clear: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> row_o == '0);
  a_r4_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (row_switch_i && !restart_i && row_o != ROW_MAX) |=> row_o == $past(row_o) + 1'b1);
  a_r4_row_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && row_o == ROW_MAX) |=> row_o == ROW_MAX);
  a_r8_prime_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(primed_o) |-> $past(restart_late_i) && !$past(init_i));

endmodule

// File: rtl/fq_ctrl_pipe.sv
// Fixed-latency control output: the strobe chain times the ready pulse,
// and the data chain carries the registered bank read to the output.
module fq_ctrl_pipe #(
  parameter int DATA_W   = 40,
  parameter int CTRL_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_switch_i,
  input  logic              zero_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] ctrl_dat_o,
  output logic              ctrl_rdy_o
);
  localparam int STG_N  = CTRL_LAT - 1;
  localparam int PIPE_N = CTRL_LAT - 3;

  logic [STG_N-1:0]  stage_q, stage_d;
  logic [DATA_W-1:0] dpipe_q [PIPE_N];
  logic [DATA_W-1:0] dpipe_d [PIPE_N];
  logic              load_en;

  assign load_en = stage_q[STG_N-1];

  always_comb begin
    stage_d    = {stage_q[STG_N-2:0], row_switch_i};
    dpipe_d[0] = rd_data_i;
    for (int i = 1; i < PIPE_N; i++) dpipe_d[i] = dpipe_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= '0;
      ctrl_rdy_o <= 1'b0;
      ctrl_dat_o <= '0;
    end else begin
      stage_q    <= stage_d;
      ctrl_rdy_o <= load_en;
      if (load_en) ctrl_dat_o <= zero_i ? '0 : dpipe_q[PIPE_N-1];
    end
  end

  // Data path registers carry no reset; the output gate covers their start-up.
  always_ff @(posedge clk) begin
    dpipe_q <= dpipe_d;
  end

  a_r5_rdy_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdy_o |-> $past(row_switch_i, CTRL_LAT));
  a_r5_dat_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdy_o |-> $stable(ctrl_dat_o));

endmodule

// File: rtl/frame_queue_ctrl.sv
module frame_queue_ctrl
  import frame_queue_pkg::*;
#(
  parameter int DATA_W   = 40,
  parameter int ADDR_W   = 6,
  parameter int CTRL_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_switch_i,
  input  logic              frame_restart_i,
  input  logic              frame_restart_late_i,
  input  logic              init_win_i,
  input  logic              wr_en_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [DATA_W-1:0] ctrl_dat_o,
  output logic              ctrl_rdy_o,
  output logic [DATA_W-1:0] bus_dat_o
);
  localparam int N_BANKS = 2;

  logic              cur_bank, primed;
  logic [ADDR_W-1:0] row;
  logic              upd;
  logic              zero_now;
  logic              prev_sel_q, bus_zero_q;
  logic [DATA_W-1:0] rd_ctrl [N_BANKS];
  logic [DATA_W-1:0] rd_bus  [N_BANKS];
  logic [DATA_W-1:0] ctrl_rd;

  fq_row_tracker #(.ADDR_W(ADDR_W)) u_track (
    .clk            (clk),
    .rst_n          (rst_n),
    .row_switch_i   (row_switch_i),
    .restart_i      (frame_restart_i),
    .restart_late_i (frame_restart_late_i),
    .init_i         (init_win_i),
    .cur_bank_o     (cur_bank),
    .row_o          (row),
    .primed_o       (primed)
  );

  assign upd      = wr_en_i && mode_updates(servo_mode_e'(mode_i));
  assign zero_now = init_win_i || !primed;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    fq_bank_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .clk     (clk),
      .we      (upd && (cur_bank == 1'(b))),
      .waddr   (row),
      .wdata   (wr_data_i),
      .raddr_a (row),
      .rdata_a (rd_ctrl[b]),
      .raddr_b (bus_addr_i),
      .rdata_b (rd_bus[b])
    );
  end

  // The previous-bank select and the zero gate are registered alongside the reads.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel_q <= 1'b1;
      bus_zero_q <= 1'b1;
    end else begin
      prev_sel_q <= ~cur_bank;
      bus_zero_q <= zero_now;
    end
  end

  assign ctrl_rd   = rd_ctrl[prev_sel_q];
  assign bus_dat_o = bus_zero_q ? '0 : rd_bus[prev_sel_q];

  fq_ctrl_pipe #(.DATA_W(DATA_W), .CTRL_LAT(CTRL_LAT)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .row_switch_i (row_switch_i),
    .zero_i       (zero_now),
    .rd_data_i    (ctrl_rd),
    .ctrl_dat_o   (ctrl_dat_o),
    .ctrl_rdy_o   (ctrl_rdy_o)
  );

  a_r7_bus_zero_window: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init_win_i) |-> bus_dat_o == '0);
  a_r1_reads_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
    prev_sel_q != $past(cur_bank));

endmodule

// File: tb/frame_queue_ctrl_tb.sv
module frame_queue_ctrl_tb;
  localparam int DW      = 40;
  localparam int AW      = 6;
  localparam int DEPTH   = 1 << AW;
  localparam int ROW_CYC = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          row_switch, restart, restart_late, init_win, wr_en;
  logic [1:0]    mode;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] ctrl_dat, bus_dat;
  logic          ctrl_rdy;

  always #10 clk = ~clk;

  frame_queue_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .row_switch_i(row_switch),
    .frame_restart_i(restart), .frame_restart_late_i(restart_late),
    .init_win_i(init_win), .wr_en_i(wr_en), .mode_i(mode),
    .wr_data_i(wr_data), .bus_addr_i(bus_addr),
    .ctrl_dat_o(ctrl_dat), .ctrl_rdy_o(ctrl_rdy), .bus_dat_o(bus_dat)
  );

  int      checks = 0;
  int      fails  = 0;
  bit      done   = 0;
  int      bank_m = 0;
  int      row_m  = 0;
  bit      primed_m = 0;
  string   tag_ctrl = "R1";
  logic [DW-1:0] mdl [2][DEPTH];
  bit            vld [2][DEPTH];

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic string gate_tag(bit in_init, string dflt);
    if (in_init) return "R7";
    if (!primed_m) return "R8";
    return dflt;
  endfunction

  // wsel: 0 no write, 1 random mode, 2 strobe with mode 2'b00
  task automatic do_row(bit rs, bit late, bit in_init, int wsel);
    logic [DW-1:0] exp_c, exp_b;
    bit            chk_c, chk_b, gate;
    int            ba;
    logic [1:0]    m;
    logic [63:0]   r64;
    string         tc, tb;
    @(negedge clk);
    row_switch = 1; restart = rs; restart_late = late; init_win = in_init; wr_en = 0;
    @(negedge clk);
    row_switch = 0; restart = 0; restart_late = 0;
    if (rs) begin bank_m ^= 1; row_m = 0; end
    else if (row_m < DEPTH-1) row_m++;
    if (in_init) primed_m = 0; else if (late) primed_m = 1;
    gate  = in_init || !primed_m;
    chk_c = gate || vld[1-bank_m][row_m];
    exp_c = gate ? '0 : mdl[1-bank_m][row_m];
    if (gate) tc = gate_tag(in_init, "");
    else if (row_m == DEPTH-1) tc = "R4";
    else if (row_m == 0) tc = "R3";
    else tc = tag_ctrl;
    chk_b = 0; exp_b = '0; tb = "R6";
    for (int k = 1; k < ROW_CYC; k++) begin
      if (k > 1) @(negedge clk);
      if (k >= 2 && k <= 5) check("R5", DW'(ctrl_rdy), DW'(k == 4));
      if (k == 4 && chk_c) check(tc, ctrl_dat, exp_c);
      if (k == 6 && chk_b) check(tb, bus_dat, exp_b);
      if (k == 2 && wsel != 0) begin
        m   = (wsel == 2) ? 2'b00 : 2'($urandom());
        r64 = {$urandom(), $urandom()};
        wr_en = 1; mode = m; wr_data = r64[DW-1:0];
        if (m != 2'b00) begin
          mdl[bank_m][row_m] = r64[DW-1:0];
          vld[bank_m][row_m] = 1;
        end
      end
      if (k == 3) begin wr_en = 0; mode = 2'($urandom()); end
      if (k == 5) begin
        ba = int'($urandom() % DEPTH);
        bus_addr = AW'(ba);
        chk_b = gate || vld[1-bank_m][ba];
        exp_b = gate ? '0 : mdl[1-bank_m][ba];
        tb = gate ? gate_tag(in_init, "") : "R6";
      end
    end
  endtask

  task automatic do_frame(int nrows, bit in_init, int wsel);
    for (int r = 0; r < nrows; r++) do_row(r == 0, r == 1, in_init, wsel);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n = 0; row_switch = 0; restart = 0; restart_late = 0; init_win = 0;
    wr_en = 0; mode = 2'b00; wr_data = '0; bus_addr = '0;
    repeat (3) @(negedge clk);
    check("R9", DW'(ctrl_rdy), '0);
    check("R9", ctrl_dat, '0);
    check("R9", bus_dat, '0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R9", bus_dat, '0);
    // random filling frames; the first reads run unprimed (R8)
    do_frame(41, 0, 1);
    do_frame(41, 0, 1);
    do_frame(41, 0, 1);
    // all updates with mode 00: next frame must see the older bank (R2)
    do_frame(41, 0, 2);
    tag_ctrl = "R2";
    do_frame(41, 0, 1);
    tag_ctrl = "R1";
    // initialize window (R7), then unprimed first row (R8)
    do_frame(41, 1, 1);
    do_frame(41, 0, 1);
    // long frame pins the row address at the top (R4)
    do_frame(70, 0, 1);
    do_frame(41, 0, 1);
    do_frame(41, 0, 0);
    finish_run();
  end

endmodule